// File: doc/BRIEF.md
# Receiver Power-of-Two Gain Stage with Frame AGC

This block scales a stream of 16-bit signed I/Q baseband samples by a power of two before they enter later receive processing. Left shifts amplify, with clipping to the signed rails. Right shifts attenuate. The gain comes either from a host code or from an automatic loop that revises the gain once per frame.

Per-frame statistics are gathered on the scaled samples: the number of clipped samples and the largest magnitude seen. When a frame-boundary pulse arrives, these statistics are published on the outputs and the accumulators restart. At the same moment, if the automatic loop is on, it steps the gain down after a frame that clipped. It steps the gain up only after a run of weak frames. A 4-bit code reports the gain that is currently applied, in the same encoding the host uses.

Top module: `rx_pow2_gain`

## Requirements
- R1: In the gain code, bit 3 = 0 means amplify and bits 2:0 give a left shift of 0 to 7 bits. For example, code 4'h3 multiplies each sample by 8.
- R2: In the gain code, bit 3 = 1 means attenuate by an arithmetic right shift of bits 2:0. Results round toward minus infinity, so -5 with code 4'hA gives -2 and -1 with code 4'hF stays -1.
- R3: With code 4'h0 and the automatic loop off, the output samples equal the input samples exactly.
- R4: A left-shifted result that does not fit in 16 signed bits becomes +32767 if the input was positive and -32768 if it was negative. A result that fits exactly, such as -16384 shifted by one, is not clipped.
- R5: The saturation count is the number of valid samples in a frame where the I lane, the Q lane or both clipped. It stops at 255.
- R6: The peak output is bits 15:8 of the largest max(|I|,|Q|) among the frame's scaled samples. The magnitude of -32768 is taken as 32767.
- R7: Output samples appear one clock after the input sample, with the output valid aligned to them. The saturation count and the peak change only in the cycle after a frame-boundary pulse, and they reset to 0.
- R8: With the automatic loop off (enable = 0), the host code sets the gain and is reported on the gain output. With the loop on (enable = 1), an internal gain applies instead. That internal gain resets to 0 and holds its value while the loop is off.
- R9: With the loop on, a frame-boundary pulse that ends a frame with any clipped sample lowers the internal gain by the attack step and clears the weak-frame run.
- R10: With the loop on, a frame is weak if it has no clip and its peak is below the target. The gain rises by the decay step on the weak frame that finds a run of at least holdoff earlier consecutive weak frames; that rise also clears the run. A frame that is not weak clears the run.
- R11: The internal gain is clamped between right-shift-7 and left-shift-7. It is reported as 4'b0nnn for an amplification of n and 4'b1nnn for an attenuation of n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input I sample, signed |
| in_q | input | 16 | Input Q sample, signed |
| gain_code | input | 4 | Host gain code (bit 3 direction, bits 2:0 shift) |
| agc_en | input | 1 | 1 = automatic gain, 0 = host gain |
| agc_target | input | 8 | Peak threshold below which a frame is weak |
| agc_attack | input | 4 | Gain decrease after a clipping frame |
| agc_decay | input | 4 | Gain increase after enough weak frames |
| agc_holdoff | input | 4 | Weak frames required before an increase |
| frame_pulse | input | 1 | One-cycle frame boundary |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Scaled I sample, signed |
| out_q | output | 16 | Scaled Q sample, signed |
| sat_count | output | 8 | Clipped samples in the last frame |
| peak_mag | output | 8 | Upper bits of the last frame's peak magnitude |
| gain_now | output | 4 | Gain code currently in effect |

## Verification
The bench aims at the clipping boundary. A design that compares against the wrong rail would clip -16384 shifted by one, or would wrap 32768 to a negative value instead of pinning it at +32767. The bench checks negative right shifts, where a logical shift would turn -5 into a large positive number. It also sends a 300-sample clipping burst, which a counter without a stop would wrap past 255. In the loop, the bench places a strong frame between weak frames, so a run counter that failed to clear would raise the gain one frame early. It also drives the gain past both clamp limits with steps of 15, which an unclamped loop would carry to an out-of-range code.

// File: rtl/rxg_pkg.sv
`timescale 1ns/1ps
package rxg_pkg;
  localparam int MAX_SHIFT = 7;
  typedef logic signed [4:0] gain_t;

  function automatic gain_t code_to_gain(input logic [3:0] c);
    gain_t m;
    m = gain_t'({2'b00, c[2:0]});
    return c[3] ? -m : m;
  endfunction

  function automatic logic [3:0] gain_to_code(input gain_t g);
    gain_t m;
    m = (g < 0) ? -g : g;
    return {(g < 0) ? 1'b1 : 1'b0, m[2:0]};
  endfunction
endpackage

// File: rtl/rxg_shifter.sv
`timescale 1ns/1ps
module rxg_shifter
  import rxg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic [LANES*DATA_W-1:0] din,
  input  gain_t                   gain,
  output logic                    valid_o,
  output logic [LANES*DATA_W-1:0] dout,
  output logic [LANES*DATA_W-1:0] scaled,
  output logic [LANES-1:0]        clip
);
  localparam int WIDE_W = DATA_W + MAX_SHIFT;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  gain_t      mag_g;
  logic [2:0] amt;
  logic       left;

  assign left  = (gain > 0);
  assign mag_g = (gain < 0) ? -gain : gain;
  assign amt   = mag_g[2:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [DATA_W-1:0] x;
    logic signed [WIDE_W-1:0] wide;
    logic [MAX_SHIFT:0]       top;
    logic                     fits;
    logic [DATA_W-1:0]        res;
    logic                     clip_l;

    assign x    = din[l*DATA_W +: DATA_W];
    assign wide = {{MAX_SHIFT{x[DATA_W-1]}}, x} <<< amt;
    assign top  = wide[WIDE_W-1:DATA_W-1];
    assign fits = (&top) | (~|top);

    always_comb begin
      clip_l = 1'b0;
      if (left && !fits) begin
        clip_l = 1'b1;
        res    = x[DATA_W-1] ? NEG_MIN : POS_MAX;
      end else if (left) begin
        res = wide[DATA_W-1:0];
      end else begin
        res = x >>> amt;
      end
    end

    assign scaled[l*DATA_W +: DATA_W] = res;
    assign clip[l] = clip_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      dout    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) dout <= scaled;
    end
  end

  AST_CLIP_NEEDS_LEFT: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (|clip)) |-> (gain > 0)); // R4
endmodule

// File: rtl/rxg_stats.sv
`timescale 1ns/1ps
module rxg_stats #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int STAT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_i,
  input  logic                    valid_i,
  input  logic [LANES*DATA_W-1:0] samp,
  input  logic [LANES-1:0]        clip,
  output logic [STAT_W-1:0]       sat_cnt_o,
  output logic [STAT_W-1:0]       peak_o,
  output logic                    acc_clip_o,
  output logic [STAT_W-1:0]       acc_peak_o
);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [LANES*DATA_W-1:0] lane_mag;
  logic [DATA_W-1:0]       samp_mag;
  logic [STAT_W-1:0]       acc_sat;
  logic [DATA_W-1:0]       acc_peak;
  logic                    any_clip;

  for (genvar l = 0; l < LANES; l++) begin : g_mag
    logic [DATA_W-1:0] x;
    assign x = samp[l*DATA_W +: DATA_W];
    assign lane_mag[l*DATA_W +: DATA_W] =
      !x[DATA_W-1] ? x : ((x == NEG_MIN) ? POS_MAX : (~x + 1'b1));
  end

  always_comb begin
    samp_mag = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_mag[l*DATA_W +: DATA_W] > samp_mag) samp_mag = lane_mag[l*DATA_W +: DATA_W];
    end
  end

  assign any_clip = valid_i & (|clip);

  always_ff @(posedge clk) begin
    if (rst) begin
      sat_cnt_o <= '0;
      peak_o    <= '0;
      acc_sat   <= '0;
      acc_peak  <= '0;
    end else if (frame_i) begin
      sat_cnt_o <= acc_sat;
      peak_o    <= acc_peak[DATA_W-1 -: STAT_W];
      acc_sat   <= STAT_W'(any_clip);
      acc_peak  <= valid_i ? samp_mag : '0;
    end else if (valid_i) begin
      if (any_clip && (acc_sat != '1)) acc_sat <= acc_sat + 1'b1;
      if (samp_mag > acc_peak) acc_peak <= samp_mag;
    end
  end

  assign acc_clip_o = (acc_sat != '0);
  assign acc_peak_o = acc_peak[DATA_W-1 -: STAT_W];

  AST_STATS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_i |=> ($stable(sat_cnt_o) && $stable(peak_o))); // R7
  AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((acc_sat != '0) && !frame_i) |=> (acc_sat != '0)); // R5
endmodule

// File: rtl/rxg_agc.sv
`timescale 1ns/1ps
module rxg_agc
  import rxg_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              frame_i,
  input  logic              clip_seen_i,
  input  logic [STAT_W-1:0] peak_i,
  input  logic [STAT_W-1:0] target_i,
  input  logic [STEP_W-1:0] attack_i,
  input  logic [STEP_W-1:0] decay_i,
  input  logic [STEP_W-1:0] holdoff_i,
  output gain_t             gain_o
);
  localparam int SUM_W = STEP_W + 2;

  logic [STEP_W-1:0]       run_q;
  logic signed [SUM_W-1:0] g_ext, down, up;

  assign g_ext = SUM_W'(gain_o);
  assign down  = g_ext - $signed({2'b00, attack_i});
  assign up    = g_ext + $signed({2'b00, decay_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_o <= '0;
      run_q  <= '0;
    end else if (en_i && frame_i) begin
      if (clip_seen_i) begin
        gain_o <= (down < -SUM_W'(MAX_SHIFT)) ? -gain_t'(MAX_SHIFT) : gain_t'(down);
        run_q  <= '0;
      end else if (peak_i < target_i) begin
        if (run_q >= holdoff_i) begin
          gain_o <= (up > SUM_W'(MAX_SHIFT)) ? gain_t'(MAX_SHIFT) : gain_t'(up);
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (gain_o >= -gain_t'(MAX_SHIFT)) && (gain_o <= gain_t'(MAX_SHIFT))); // R11
  AST_NO_RISE_ON_CLIP: assert property (@(posedge clk) disable iff (rst)
    (en_i && frame_i && clip_seen_i) |=> (gain_o <= $past(gain_o))); // R9
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(gain_o)); // R8
endmodule

// File: rtl/rx_pow2_gain.sv
`timescale 1ns/1ps
module rx_pow2_gain
  import rxg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic [3:0]        gain_code,
  input  logic              agc_en,
  input  logic [STAT_W-1:0] agc_target,
  input  logic [STEP_W-1:0] agc_attack,
  input  logic [STEP_W-1:0] agc_decay,
  input  logic [STEP_W-1:0] agc_holdoff,
  input  logic              frame_pulse,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic [STAT_W-1:0] sat_count,
  output logic [STAT_W-1:0] peak_mag,
  output logic [3:0]        gain_now
);
  localparam int LANES = 2;

  gain_t                   agc_gain, eff_gain;
  logic [LANES*DATA_W-1:0] scaled, dout;
  logic [LANES-1:0]        clip;
  logic                    acc_clip;
  logic [STAT_W-1:0]       acc_peak;

  assign eff_gain = agc_en ? agc_gain : code_to_gain(gain_code);

  rxg_shifter #(.DATA_W(DATA_W), .LANES(LANES)) u_shift (
    .clk(clk), .rst(rst), .valid_i(in_valid), .din({in_q, in_i}), .gain(eff_gain),
    .valid_o(out_valid), .dout(dout), .scaled(scaled), .clip(clip)
  );

  assign out_i = dout[DATA_W-1:0];
  assign out_q = dout[2*DATA_W-1:DATA_W];

  rxg_stats #(.DATA_W(DATA_W), .LANES(LANES), .STAT_W(STAT_W)) u_stats (
    .clk(clk), .rst(rst), .frame_i(frame_pulse), .valid_i(in_valid), .samp(scaled),
    .clip(clip), .sat_cnt_o(sat_count), .peak_o(peak_mag), .acc_clip_o(acc_clip),
    .acc_peak_o(acc_peak)
  );

  rxg_agc #(.STAT_W(STAT_W), .STEP_W(STEP_W)) u_agc (
    .clk(clk), .rst(rst), .en_i(agc_en), .frame_i(frame_pulse), .clip_seen_i(acc_clip),
    .peak_i(acc_peak), .target_i(agc_target), .attack_i(agc_attack), .decay_i(agc_decay),
    .holdoff_i(agc_holdoff), .gain_o(agc_gain)
  );

  always_ff @(posedge clk) begin
    if (rst) gain_now <= '0;
    else     gain_now <= agc_en ? gain_to_code(agc_gain) : gain_code;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (gain_code == 4'h0) && !agc_en) |=>
    (out_valid && (out_i == $past(in_i)) && (out_q == $past(in_q)))); // R3
  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q))); // R7
endmodule

// File: tb/rx_pow2_gain_tb.sv
`timescale 1ns/1ps
module rx_pow2_gain_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic [3:0] gain_code = '0;
  logic agc_en = 1'b0;
  logic [7:0] agc_target = '0;
  logic [3:0] agc_attack = '0, agc_decay = '0, agc_holdoff = '0;
  logic frame_pulse = 1'b0;
  logic out_valid;
  logic [15:0] out_i, out_q;
  logic [7:0] sat_count, peak_mag;
  logic [3:0] gain_now;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_pow2_gain u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .gain_code(gain_code), .agc_en(agc_en), .agc_target(agc_target),
    .agc_attack(agc_attack), .agc_decay(agc_decay), .agc_holdoff(agc_holdoff),
    .frame_pulse(frame_pulse), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .sat_count(sat_count), .peak_mag(peak_mag), .gain_now(gain_now)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_scale(input int x, input logic [3:0] code);
    int v;
    if (code[3]) return x >>> code[2:0];
    v = x * (1 << code[2:0]);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input int a, input int b);
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(a); in_q = 16'(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_chk(input string req, input int a, input int b, input int ea, input int eb);
    send(a, b);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " I"}, int'($signed(out_i)), ea);
    chk({req, " Q"}, int'($signed(out_q)), eb);
  endtask

  task automatic pulse();
    @(negedge clk);
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R7 reset valid", int'(out_valid), 0);
    chk("R7 reset I", int'(out_i), 0);
    chk("R7 reset sat", int'(sat_count), 0);
    chk("R7 reset peak", int'(peak_mag), 0);
    chk("R8 reset gain", int'(gain_now), 0);
  endtask

  task automatic t_pass();
    gain_code = 4'h0;
    send_chk("R3 pass", 1234, -5678, 1234, -5678);
    send_chk("R3 pass rails", -32768, 32767, -32768, 32767);
    @(negedge clk);
    chk("R7 valid drops", int'(out_valid), 0);
  endtask

  task automatic t_left();
    gain_code = 4'h3;
    send_chk("R1 left3", 100, -100, exp_scale(100, 4'h3), exp_scale(-100, 4'h3));
    chk("R1 left3 literal", int'($signed(out_i)), 800);
  endtask

  task automatic t_right();
    gain_code = 4'hA;
    send_chk("R2 right2", -5, 7, -2, 1);
    gain_code = 4'hF;
    send_chk("R2 right7", -1, 300, -1, 2);
  endtask

  task automatic t_clip();
    pulse();
    gain_code = 4'h1;
    send_chk("R4 clip pos", 16384, -16384, 32767, -32768);
    send_chk("R4 exact fit", -16384, 0, -32768, 0);
    send_chk("R4 clip neg", -20000, 5, -32768, 10);
    chk("R7 stats held", int'(sat_count), 0);
    pulse();
    chk("R5 sat count", int'(sat_count), 2);
    chk("R6 peak rail", int'(peak_mag), 8'h7F);
  endtask

  task automatic t_peak();
    gain_code = 4'h0;
    send(300, -16'sh1234);
    send(16'h0FFF, 0);
    pulse();
    chk("R6 peak", int'(peak_mag), 8'h12);
    chk("R5 no clip", int'(sat_count), 0);
    send(-32768, 0);
    pulse();
    chk("R6 neg min", int'(peak_mag), 8'h7F);
  endtask

  task automatic t_satcnt();
    gain_code = 4'h7;
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'd1000; in_q = 16'd0;
    repeat (300) @(negedge clk);
    in_valid = 1'b0;
    pulse();
    chk("R5 count stops at 255", int'(sat_count), 255);
  endtask

  task automatic t_manual_code();
    gain_code = 4'hD;
    repeat (2) @(negedge clk);
    chk("R8 manual report", int'(gain_now), 4'hD);
  endtask

  task automatic t_agc();
    do_reset();
    agc_target = 8'h20; agc_attack = 4'd3; agc_decay = 4'd2; agc_holdoff = 4'd1;
    gain_code = 4'h7;
    agc_en = 1'b1;
    send_chk("R8 agc ignores code", 1000, 0, 1000, 0);
    chk("R8 agc start", int'(gain_now), 4'h0);
    pulse();
    chk("R10 first weak held", int'(gain_now), 4'h0);
    pulse();
    chk("R10 rise after holdoff", int'(gain_now), 4'h2);
    send_chk("R8 agc gain applied", 1000, 0, 4000, 0);
    send(20000, 0);
    pulse();
    chk("R9 attack", int'(gain_now), 4'h9);
    send_chk("R11 negative gain", -8, 0, -4, 0);
    pulse();
    chk("R10 weak run 1", int'(gain_now), 4'h9);
    send(30000, 0);
    pulse();
    chk("R10 strong frame", int'(gain_now), 4'h9);
    pulse();
    chk("R10 run cleared", int'(gain_now), 4'h9);
    pulse();
    chk("R10 rise", int'(gain_now), 4'h1);
    agc_decay = 4'd15; agc_holdoff = 4'd0;
    pulse();
    chk("R11 clamp high", int'(gain_now), 4'h7);
    agc_attack = 4'd15;
    send(1000, 0);
    pulse();
    chk("R11 clamp low", int'(gain_now), 4'hF);
    agc_en = 1'b0;
    gain_code = 4'h7;
    pulse();
    chk("R8 off reports code", int'(gain_now), 4'h7);
    agc_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 gain held while off", int'(gain_now), 4'hF);
    agc_en = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_pass();
    t_left();
    t_right();
    t_clip();
    t_peak();
    t_satcnt();
    t_manual_code();
    t_agc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule